// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls a 32-pin general-purpose I/O port through a word-addressed 32-bit register bus. For every pin it holds an output value, a drive-enable bit and an open-drain enable bit. It also holds a 2-bit output-source field and a 2-bit drive-source field. These fields let the pin either follow its own registers or pass through the signals of one of three alternate peripheral buses. The block drives three control vectors for external pad cells: output value, output enable and open-drain flag. It also samples the pad levels through a synchronizer so that software can read them back.

Register bits are numbered from the most significant end: pin n sits at bit 31-n of every register that has one bit per pin. The pad and alternate-bus vectors are indexed by pin number, so pin n is bit n of those vectors. A write takes effect on the clock edge on which `req_i` and `we_i` are high. Read data follows `addr_i` combinationally.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, words 0 to 7 all read zero (while the pins are held low), and `pad_oe_o` and `pad_od_o` are zero on every pin.
- R2: A write to word 0 (output value), 1 (drive enable) or 6 (open-drain enable) takes effect at the clock edge that accepts it, and the word then reads back the written data. Register bit 31-n controls pin n; for example, 0x80000000 in words 0 and 1 drives pad 0 high.
- R3: When both select fields of pin n are 00 and open-drain is off, `pad_out_o[n]` equals bit 31-n of word 0 and `pad_oe_o[n]` equals bit 31-n of word 1 (1 = drive, 0 = float).
- R4: The output-source field of pin n is bits [31-2k : 30-2k], with k = n mod 16. It lives in word 2 for pins 0 to 15 and in word 3 for pins 16 to 31. A field value of s in 1..3 makes `pad_out_o[n]` follow `alt_out_i[s-1][n]`.
- R5: The drive-source field uses the same bit positions, in word 4 for pins 0 to 15 and in word 5 for pins 16 to 31. A field value of s in 1..3 makes the pin's drive enable follow `alt_oe_i[s-1][n]`.
- R6: When bit 31-n of word 6 is 1, `pad_od_o[n]` is 1 and `pad_out_o[n]` is 0. In that case `pad_oe_o[n]` is 1 only when the selected drive enable is 1 and the selected output value is 0.
- R7: Word 7 returns the pin levels with pin n at bit 31-n. A change on `pin_i` becomes visible there after exactly two rising clock edges.
- R8: Writes to word 7 have no effect. Words 8 to 31 read zero and ignore writes; in particular, such writes leave words 0 to 6 unchanged.
- R9: For one pin, the output-source field and the drive-source field choose their sources independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | ADDR_W (5) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 32 | Pad input levels, bit n = pin n |
| alt_out_i | input | 3x32 | Alternate output values, [s-1][n] for source s, pin n |
| alt_oe_i | input | 3x32 | Alternate drive enables, [s-1][n] |
| pad_out_o | output | 32 | Pad output value, bit n = pin n |
| pad_oe_o | output | 32 | Pad output enable, bit n = pin n |
| pad_od_o | output | 32 | Pad open-drain flag, bit n = pin n |

## Verification
The bench uses the default parameters: ADDR_W of 5 and SYNC_STAGES of 2. With a 5-bit address, the bench can reach the unmapped words above the register block, up to word 31, and can check that writes to them leave the live registers untouched. Two synchronizer stages give the exact two-edge latency that the bench measures on the input word.

The random phase draws every register, every alternate bus and the pin levels together. This exercises all four source choices for the output and the drive enable of each pin, both halves of the select words, and open-drain and push-pull mode at once. Directed cases pin down the boundary pins 15 and 16, the MSB-first mapping of pin 0, and the case where the two select fields of one pin point at different sources.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPINS  = 32;
  localparam int DW     = 32;
  localparam int SEL_W  = 2;
  localparam int NALT   = (1 << SEL_W) - 1;
  localparam int HALF   = DW / SEL_W;   // pins per select word
  localparam int NRW    = 7;            // writable words 0..6
  localparam int A_OUT  = 0;
  localparam int A_TCR  = 1;
  localparam int A_OSL  = 2;
  localparam int A_OSH  = 3;
  localparam int A_TSL  = 4;
  localparam int A_TSH  = 5;
  localparam int A_OD   = 6;
  localparam int A_IN   = 7;

  function automatic logic [NPINS-1:0] rev_bits(input logic [NPINS-1:0] x);
    logic [NPINS-1:0] r;
    for (int i = 0; i < NPINS; i++) r[i] = x[NPINS-1-i];
    return r;
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NPINS-1:0]  in_lvl_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     out_q_o,
  output logic [DW-1:0]     tcr_q_o,
  output logic [DW-1:0]     od_q_o,
  output logic [DW-1:0]     osl_q_o,
  output logic [DW-1:0]     osh_q_o,
  output logic [DW-1:0]     tsl_q_o,
  output logic [DW-1:0]     tsh_q_o
);
  logic [DW-1:0] rw_q [NRW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NRW; i++) rw_q[i] <= '0;
    end else begin
      for (int i = 0; i < NRW; i++)
        if (req_i && we_i && addr_i == ADDR_W'(i)) rw_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NRW; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = rw_q[i];
    if (addr_i == ADDR_W'(A_IN)) rdata_o = rev_bits(in_lvl_i);
  end

  assign out_q_o = rw_q[A_OUT];
  assign tcr_q_o = rw_q[A_TCR];
  assign osl_q_o = rw_q[A_OSL];
  assign osh_q_o = rw_q[A_OSH];
  assign tsl_q_o = rw_q[A_TSL];
  assign tsh_q_o = rw_q[A_TSH];
  assign od_q_o  = rw_q[A_OD];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
(
  input  logic             reg_out_i,
  input  logic             reg_oe_i,
  input  logic             od_en_i,
  input  logic [SEL_W-1:0] osel_i,
  input  logic [SEL_W-1:0] tsel_i,
  input  logic [NALT-1:0]  alt_out_i,
  input  logic [NALT-1:0]  alt_oe_i,
  output logic             pad_out_o,
  output logic             pad_oe_o
);
  logic val, drv;

  always_comb begin
    val = (osel_i == '0) ? reg_out_i : alt_out_i[osel_i - SEL_W'(1)];
    drv = (tsel_i == '0) ? reg_oe_i  : alt_oe_i[tsel_i - SEL_W'(1)];
    if (od_en_i) begin
      // open drain: pull low only, release for a one
      pad_out_o = 1'b0;
      pad_oe_o  = drv & ~val;
    end else begin
      pad_out_o = val;
      pad_oe_o  = drv;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic [NPINS-1:0]           pin_i,
  input  logic [NALT-1:0][NPINS-1:0] alt_out_i,
  input  logic [NALT-1:0][NPINS-1:0] alt_oe_i,
  output logic [NPINS-1:0]           pad_out_o,
  output logic [NPINS-1:0]           pad_oe_o,
  output logic [NPINS-1:0]           pad_od_o
);
  logic [NPINS-1:0] in_lvl;
  logic [DW-1:0] out_q, tcr_q, od_q, osl_q, osh_q, tsl_q, tsh_q;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(in_lvl)
  );

  gpio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .in_lvl_i(in_lvl), .rdata_o,
    .out_q_o(out_q), .tcr_q_o(tcr_q), .od_q_o(od_q),
    .osl_q_o(osl_q), .osh_q_o(osh_q), .tsl_q_o(tsl_q), .tsh_q_o(tsh_q)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int RB = NPINS - 1 - n;
    localparam int FH = DW - 1 - SEL_W * (n % HALF);
    logic [SEL_W-1:0] osel, tsel;
    logic [NALT-1:0]  a_out, a_oe;

    if (n < HALF) begin : g_lo
      assign osel = osl_q[FH -: SEL_W];
      assign tsel = tsl_q[FH -: SEL_W];
    end else begin : g_hi
      assign osel = osh_q[FH -: SEL_W];
      assign tsel = tsh_q[FH -: SEL_W];
    end

    for (genvar s = 0; s < NALT; s++) begin : g_alt
      assign a_out[s] = alt_out_i[s][n];
      assign a_oe[s]  = alt_oe_i[s][n];
    end

    gpio_pin_cell u_cell (
      .reg_out_i(out_q[RB]), .reg_oe_i(tcr_q[RB]), .od_en_i(od_q[RB]),
      .osel_i(osel), .tsel_i(tsel), .alt_out_i(a_out), .alt_oe_i(a_oe),
      .pad_out_o(pad_out_o[n]), .pad_oe_o(pad_oe_o[n])
    );

    assign pad_od_o[n] = od_q[RB];
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DW-1:0]              wdata_i,
  input logic [DW-1:0]              rdata_o,
  input logic [NPINS-1:0]           pin_i,
  input logic [NALT-1:0][NPINS-1:0] alt_out_i,
  input logic [NALT-1:0][NPINS-1:0] alt_oe_i,
  input logic [NPINS-1:0]           pad_out_o,
  input logic [NPINS-1:0]           pad_oe_o,
  input logic [NPINS-1:0]           pad_od_o
);
  logic [1:0] cyc_q;
  logic       alt_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign alt_seen = |{alt_out_i, alt_oe_i};

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0 && !alt_seen) |-> (pad_oe_o == '0 && pad_od_o == '0));

  assert_write_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i < ADDR_W'(NRW)) |=>
      (addr_i != $past(addr_i) || rdata_o == $past(wdata_i)));

  assert_od_never_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_od_o & pad_out_o) == '0);

  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(A_IN)) |-> rdata_o == '0);

  if (SYNC_STAGES == 2) begin : g_lat
    assert_in_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 2'd2 && addr_i == ADDR_W'(A_IN)) |->
        rdata_o == rev_bits($past(pin_i, 2)));
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam int AW = 5;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [31:0] pin_i = '0;
  logic [2:0][31:0] alt_out_i = '0, alt_oe_i = '0;
  logic [31:0] pad_out_o, pad_oe_o, pad_od_o;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m [7];
  logic [31:0] eo, ee, rd;

  gpio_port_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (a < 7) m[a] = d;
  endtask

  task automatic rdw(input int a, output logic [31:0] d);
    addr_i = AW'(a);
    #1 d = rdata_o;
  endtask

  function automatic logic [31:0] rv(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [1:0] fld(input logic [31:0] lo, input logic [31:0] hi, input int n);
    logic [31:0] w;
    w = (n < 16) ? lo : hi;
    return w[31 - 2*(n % 16) -: 2];
  endfunction

  task automatic model(output logic [31:0] o, output logic [31:0] e);
    for (int n = 0; n < 32; n++) begin
      logic [1:0] os, ts;
      logic v, d;
      os = fld(m[2], m[3], n);
      ts = fld(m[4], m[5], n);
      v = (os == 0) ? m[0][31-n] : alt_out_i[os-1][n];
      d = (ts == 0) ? m[1][31-n] : alt_oe_i[ts-1][n];
      if (m[6][31-n]) begin o[n] = 1'b0; e[n] = d & ~v; end
      else begin o[n] = v; e[n] = d; end
    end
  endtask

  task automatic chk_pads(input string r);
    #1 model(eo, ee);
    chk({r, " pad_out"}, pad_out_o, eo);
    chk({r, " pad_oe"}, pad_oe_o, ee);
    chk({r, " pad_od"}, pad_od_o, rv(m[6]));
  endtask

  initial begin
    #(20.0 * 200000);
    n_fail++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 7; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rdw(a, rd); chk("R1 reset word", rd, 32'h0); end
    chk("R1 reset pad_oe", pad_oe_o, 32'h0);
    chk("R1 reset pad_od", pad_od_o, 32'h0);

    // R2 readback and MSB-first mapping
    wr(0, 32'h8000_0000); wr(1, 32'h8000_0000);
    #1 chk("R2 pin0 out", {31'h0, pad_out_o[0]}, 32'h1);
    chk("R2 pin0 oe", pad_oe_o, 32'h0000_0001);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] d0, d1, d6;
      d0 = $urandom; d1 = $urandom; d6 = $urandom;
      wr(0, d0); wr(1, d1); wr(6, d6);
      rdw(0, rd); chk("R2 word0", rd, d0);
      rdw(1, rd); chk("R2 word1", rd, d1);
      rdw(6, rd); chk("R2 word6", rd, d6);
    end

    // R3 register path, push-pull
    wr(6, 32'h0);
    wr(0, 32'hA5A5_0F0F); wr(1, 32'hFFFF_0000);
    alt_out_i = {3{32'hFFFF_FFFF}}; alt_oe_i = '0;
    chk_pads("R3");

    // R4 boundary pins 15 / 16 on alternate output buses
    wr(0, 32'h0); wr(1, 32'h0);
    wr(2, 32'h0000_0003); wr(3, 32'h4000_0000);
    alt_out_i = '0;
    alt_out_i[0][16] = 1'b1; alt_out_i[2][15] = 1'b1;
    #1 chk("R4 pin15 alt3", {31'h0, pad_out_o[15]}, 32'h1);
    chk("R4 pin16 alt1", {31'h0, pad_out_o[16]}, 32'h1);
    chk_pads("R4");

    // R5 drive source on the same boundary pins
    wr(4, 32'h0000_0002); wr(5, 32'hC000_0000);
    alt_oe_i = '0;
    alt_oe_i[1][15] = 1'b1; alt_oe_i[2][16] = 1'b1;
    chk_pads("R5");

    // R9 independent selects on pin 0: out from bus1, drive from bus2
    wr(2, 32'h4000_0000); wr(4, 32'h8000_0000);
    alt_out_i = '0; alt_oe_i = '0;
    alt_out_i[0][0] = 1'b1; alt_oe_i[1][0] = 1'b1;
    #1 chk("R9 pin0", {30'h0, pad_out_o[0], pad_oe_o[0]}, 32'h3);
    alt_oe_i[0][0] = 1'b1; alt_oe_i[1][0] = 1'b0;
    #1 chk("R9 pin0 oe off", {31'h0, pad_oe_o[0]}, 32'h0);

    // R6 open drain on register path
    wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0);
    wr(0, 32'hF0F0_F0F0); wr(1, 32'hFF00_FF00); wr(6, 32'hFFFF_FFFF);
    chk_pads("R6");

    // random mix
    for (int it = 0; it < 40; it++) begin
      for (int a = 0; a < 7; a++) wr(a, $urandom);
      for (int s = 0; s < 3; s++) begin alt_out_i[s] = $urandom; alt_oe_i[s] = $urandom; end
      chk_pads("R3 R4 R5 R6 random");
    end

    // R7 two-edge latency
    @(negedge clk_i); pin_i = 32'h1234_5678;
    repeat (3) @(negedge clk_i);
    rdw(7, rd); chk("R7 settled", rd, rv(32'h1234_5678));
    @(negedge clk_i); pin_i = 32'hCAFE_0001;
    rdw(7, rd); chk("R7 zero edges", rd, rv(32'h1234_5678));
    @(negedge clk_i); rdw(7, rd); chk("R7 one edge", rd, rv(32'h1234_5678));
    @(negedge clk_i); rdw(7, rd); chk("R7 two edges", rd, rv(32'hCAFE_0001));

    // R8 writes to input and unmapped words
    wr(7, 32'hFFFF_FFFF);
    rdw(7, rd); chk("R8 input write ignored", rd, rv(32'hCAFE_0001));
    wr(8, 32'hDEAD_BEEF); wr(11, 32'hDEAD_BEEF); wr(17, 32'h5555_AAAA); wr(31, 32'h1111_2222);
    for (int a = 8; a < 32; a += 3) begin rdw(a, rd); chk("R8 unmapped read", rd, 32'h0); end
    rdw(31, rd); chk("R8 word31", rd, 32'h0);
    for (int a = 0; a < 7; a++) begin rdw(a, rd); chk("R8 live regs kept", rd, m[a]); end
    chk_pads("R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule